// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Interface

This block is the bus-facing half of a 128-byte serial EEPROM once the part is in bidirectional mode. It watches the two-wire bus lines, which are already synchronised to the system clock. It frames each transfer between START and STOP and checks the device select byte. On a write it takes a 7-bit byte address and collects up to eight data bytes in a page latch. On a read it shifts memory bytes back to the master. The memory array sits outside the block, behind a port with a registered address, write data and a write strobe, and a read data input of one-cycle latency.

A write command is committed only when STOP arrives. The write enable input must be high at that moment. The block then runs an internal write cycle of a fixed number of system clocks and copies the latched bytes into their page. During that cycle it ignores the bus completely. A master finds out when the write is finished by repeating START plus device select until an acknowledge comes back. SDA is driven only through an open-drain pull-down output.

Top module: `serial_eeprom_slave`

## Requirements
- R1: The block answers nothing unless a START (SDA falling while SCL is high) comes first. A byte clocked in from the idle bus gets no acknowledge. After reset the pull-down output is low.
- R2: A device select byte is accepted when its bits 7:4 are 1010. Bits 3:1 are ignored and bit 0 selects the direction (0 write, 1 read). Any other code gets no acknowledge, and every later byte is ignored until the next START.
- R3: The block acknowledges by pulling SDA low during the ninth clock after an accepted device select, the address byte and each write data byte. The pull-down changes only in the cycle after an SCL falling edge.
- R4: In a write, the byte after the device select is the address (its low 7 bits are used) and the next byte is data. A STOP with write enable high stores that byte at that address.
- R5: In a page write, only address bits 2:0 advance after each data byte, and they wrap within the 8-byte page. Bytes beyond the eighth overwrite earlier ones. Other pages are not changed.
- R6: A STOP that ends a write with stored data and write enable high starts an internal write cycle of WR_CYCLES clocks. During that cycle no acknowledge is given, not even to a device select. After it ends, a device select is acknowledged again.
- R7: When write enable is low at STOP, the data bytes are still acknowledged, but nothing is stored and no write cycle starts.
- R8: A random read (write select, address, repeated START, read select) returns the byte at the given address.
- R9: In a sequential read, each master acknowledge brings the next byte. The address advances over all 7 bits and wraps from 127 to 0.
- R10: A current-address read, which is a read select with no address, starts at the address that follows the last byte accessed.
- R11: When the master does not acknowledge a read byte, the block releases SDA and drives nothing more until the next START.
- R12: A STOP that ends a read returns the block to standby with no write cycle, so a device select right after it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line (wired level) |
| wr_en_i | input | 1 | Active-high write enable, sampled at STOP |
| sda_pd_o | output | 1 | Open-drain pull-down for SDA, 1 drives low |
| mem_addr_o | output | ADDR_W | Memory array address |
| mem_wdata_o | output | DATA_W | Memory array write data |
| mem_we_o | output | 1 | Memory array write strobe |
| mem_rdata_i | input | DATA_W | Memory array read data, one cycle after address |

## Verification
Most internal faults appear on SDA within one byte time. A wrong bit count or a bad select decode shows as a missing or misplaced acknowledge on the ninth clock. A wrong read address shows as a wrong data byte on the next read.

Faults in the page latch or the wrap logic stay hidden while the bytes are only latched. They appear only after STOP, the write cycle and a read-back. A write-cycle timer that runs too long or too short changes the number of polls that get no acknowledge. The write enable gating is visible only through a poll that is acknowledged at once and data that stays unchanged.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_ACK,
    S_ADDR,
    S_WDATA,
    S_RD,
    S_MACK,
    S_PROG
  } eep_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;

endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // a data edge while the clock stays high marks a frame boundary
  assign scl_rise = !scl_q && scl_i;
  assign scl_fall = scl_q && !scl_i;
  assign start_c  = scl_q && scl_i && sda_q && !sda_i;
  assign stop_c   = scl_q && scl_i && !sda_q && sda_i;

endmodule

// File: rtl/eep_page_latch.sv
module eep_page_latch #(
  parameter int PAGE_BYTES = 8,
  parameter int DATA_W     = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clear,
  input  logic                          wr,
  input  logic [$clog2(PAGE_BYTES)-1:0] wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          rd_valid,
  output logic                          any_valid
);

  logic [DATA_W-1:0]     slot [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr && wr_idx == i) slot[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) vld <= '0;
    else if (wr)      vld[wr_idx] <= 1'b1;
  end

  assign rd_data   = slot[rd_idx];
  assign rd_valid  = vld[rd_idx];
  assign any_valid = |vld;

endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int CYCLES = 2000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  output logic                      busy,
  output logic                      done,
  output logic [$clog2(CYCLES)-1:0] cnt
);

  localparam int W = $clog2(CYCLES);
  localparam logic [W-1:0] LAST = W'(CYCLES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) busy <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end
  end

  assign done = busy && cnt == LAST;

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eep_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wr_en_i,
  output logic              sda_pd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int TMR_W  = $clog2(WR_CYCLES);

  logic scl_rise, scl_fall, start_c, stop_c;

  eep_bus_cond u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  eep_state_e        state, ack_next;
  logic [DATA_W-1:0] shreg, txsh;
  logic [CNT_W-1:0]  bitcnt;
  logic [ADDR_W-1:0] addr;
  logic              wcmd, mack;

  logic              byte_end, go_prog;
  logic              lat_wr, lat_clr, lat_rd_valid, lat_any;
  logic [DATA_W-1:0] lat_data;
  logic              tmr_busy, tmr_done;
  logic [TMR_W-1:0]  tmr_cnt;

  assign byte_end = scl_fall && bitcnt == CNT_W'(DATA_W);
  assign go_prog  = stop_c && state != S_PROG && wcmd && lat_any && wr_en_i;
  assign lat_wr   = state == S_WDATA && byte_end && !start_c && !stop_c;
  assign lat_clr  = (state != S_PROG && start_c)
                  || (state != S_PROG && stop_c && !go_prog)
                  || (state == S_PROG && tmr_done);

  eep_page_latch #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .clear(lat_clr),
    .wr(lat_wr), .wr_idx(addr[PAGE_W-1:0]), .wr_data(shreg),
    .rd_idx(tmr_cnt[PAGE_W-1:0]), .rd_data(lat_data),
    .rd_valid(lat_rd_valid), .any_valid(lat_any)
  );

  eep_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(go_prog),
    .busy(tmr_busy), .done(tmr_done), .cnt(tmr_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      ack_next <= S_IDLE;
      sda_pd_o <= 1'b0;
      shreg    <= '0;
      txsh     <= '0;
      bitcnt   <= '0;
      addr     <= '0;
      wcmd     <= 1'b0;
      mack     <= 1'b0;
    end else if (state == S_PROG) begin
      // bus is ignored until the write cycle completes
      if (tmr_done) state <= S_IDLE;
    end else if (start_c) begin
      state    <= S_DEV;
      bitcnt   <= '0;
      sda_pd_o <= 1'b0;
      wcmd     <= 1'b0;
    end else if (stop_c) begin
      state    <= go_prog ? S_PROG : S_IDLE;
      sda_pd_o <= 1'b0;
      wcmd     <= 1'b0;
    end else begin
      case (state)
        S_DEV, S_ADDR, S_WDATA: begin
          if (scl_rise) begin
            shreg  <= {shreg[DATA_W-2:0], sda_i};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_end) begin
            bitcnt <= '0;
            if (state == S_DEV) begin
              if (shreg[DATA_W-1 -: 4] == DEV_CODE) begin
                sda_pd_o <= 1'b1;
                state    <= S_ACK;
                ack_next <= shreg[0] ? S_RD : S_ADDR;
              end else begin
                state <= S_IDLE;
              end
            end else if (state == S_ADDR) begin
              addr     <= shreg[ADDR_W-1:0];
              wcmd     <= 1'b1;
              sda_pd_o <= 1'b1;
              state    <= S_ACK;
              ack_next <= S_WDATA;
            end else begin
              addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
              sda_pd_o <= 1'b1;
              state    <= S_ACK;
              ack_next <= S_WDATA;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            if (ack_next == S_RD) begin
              txsh     <= mem_rdata_i;
              sda_pd_o <= !mem_rdata_i[DATA_W-1];
              addr     <= addr + 1'b1;
            end else begin
              sda_pd_o <= 1'b0;
            end
            state  <= ack_next;
            bitcnt <= '0;
          end
        end
        S_RD: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == CNT_W'(DATA_W)) begin
              sda_pd_o <= 1'b0;
              state    <= S_MACK;
              bitcnt   <= '0;
            end else begin
              sda_pd_o <= !txsh[DATA_W-2];
              txsh     <= txsh << 1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack <= !sda_i;
          end else if (scl_fall) begin
            if (mack) begin
              txsh     <= mem_rdata_i;
              sda_pd_o <= !mem_rdata_i[DATA_W-1];
              addr     <= addr + 1'b1;
              state    <= S_RD;
            end else begin
              sda_pd_o <= 1'b0;
              state    <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // memory port: latched page bytes are copied during the first cycles of the write cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o    <= tmr_busy && tmr_cnt < TMR_W'(PAGE_BYTES) && lat_rd_valid;
      mem_addr_o  <= tmr_busy ? {addr[ADDR_W-1:PAGE_W], tmr_cnt[PAGE_W-1:0]} : addr;
      mem_wdata_o <= lat_data;
    end
  end

endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk #(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_pd_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);

  logic scl_d;
  logic fall_c;

  always_ff @(posedge clk) begin
    if (rst) scl_d <= 1'b1;
    else     scl_d <= scl_i;
  end

  assign fall_c = scl_d && !scl_i;

  // R3
  pd_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_pd_o != $past(sda_pd_o)) |-> $past(fall_c));

  // R3
  pd_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pd_o) |-> !scl_i);

  // R6
  prog_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> !sda_pd_o);

  // R5
  page_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && $past(mem_we_o)) |->
      mem_addr_o[ADDR_W-1:PAGE_W] == $past(mem_addr_o[ADDR_W-1:PAGE_W]));

endmodule

bind serial_eeprom_slave eep_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_pd_o(sda_pd_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o)
);

// File: tb/test_serial_eeprom_slave.sv
module test_serial_eeprom_slave;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int DEPTH      = 128;

  logic       clk = 1'b0;
  logic       rst;
  logic       scl, sda_m, wr_en;
  logic       sda_pd, mem_we;
  logic [6:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  wire        sda_bus = sda_m & ~sda_pd;

  logic [7:0] mem   [DEPTH];
  logic [7:0] exp_m [DEPTH];
  logic [7:0] rbuf  [16];
  logic [7:0] wbuf  [16];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_eeprom_slave i_serial_eeprom_slave (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .wr_en_i(wr_en),
    .sda_pd_o(sda_pd), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hq(); scl = 1'b1; hq(); sda_m = 1'b0; hq(); scl = 1'b0;
  endtask

  task automatic bus_stop();
    scl = 1'b0; hq(); sda_m = 1'b0; hq(); scl = 1'b1; hq(); sda_m = 1'b1; hq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; hq(); sda_m = b[i]; hq(); scl = 1'b1; hq(); hq();
    end
    scl = 1'b0; hq(); sda_m = 1'b1; hq(); scl = 1'b1; hq();
    ack = !sda_bus;
    hq(); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; hq(); sda_m = 1'b1; hq(); scl = 1'b1; hq();
      d[i] = sda_bus;
      hq();
    end
    scl = 1'b0; hq(); sda_m = mack ? 1'b0 : 1'b1; hq(); scl = 1'b1; hq(); hq(); scl = 1'b0;
  endtask

  task automatic poll(output bit ack);
    bus_start();
    send_byte(8'hAE, ack);
    bus_stop();
  endtask

  task automatic wait_ready(string req);
    bit ack = 0;
    for (int k = 0; k < 30 && !ack; k++) poll(ack);
    chk(req, ack, 1);
  endtask

  task automatic write_bytes(string req, input logic [6:0] a, input int n);
    bit ack;
    bus_start();
    send_byte(8'hA0, ack); chk({req, " select ack"}, ack, 1);
    send_byte({1'b0, a}, ack); chk({req, " address ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack); chk({req, " data ack"}, ack, 1);
    end
    bus_stop();
  endtask

  task automatic read_seq(input logic [6:0] a, input int n);
    bit ack;
    bus_start();
    send_byte(8'hA0, ack);
    send_byte({1'b0, a}, ack);
    bus_start();
    send_byte(8'hA1, ack);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 pull-down after reset", sda_pd, 0);
    chk("R1 no write after reset", mem_we, 0);
  endtask

  task automatic t_no_start();
    bit ack;
    send_byte(8'hA0, ack);
    chk("R1 no ack without START", ack, 0);
    bus_stop();
  endtask

  task automatic t_select();
    bit ack;
    bus_start();
    send_byte(8'h50, ack); chk("R2 wrong code not acked", ack, 0);
    send_byte(8'hA0, ack); chk("R2 ignored until next START", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hAC, ack); chk("R2 don't-care bits accepted", ack, 1);
    bus_stop();
  endtask

  task automatic t_byte_write();
    bit ack;
    wbuf[0] = 8'h77;
    write_bytes("R3", 7'h20, 1);
    exp_m[7'h20] = 8'h77;
    poll(ack);
    chk("R6 no ack while writing", ack, 0);
    wait_ready("R6 ack after write cycle");
    read_seq(7'h20, 1);
    chk("R4 byte write stored", rbuf[0], exp_m[7'h20]);
    read_seq(7'h31, 1);
    chk("R8 random read", rbuf[0], exp_m[7'h31]);
  endtask

  task automatic t_page_write();
    logic [6:0] a;
    for (int k = 0; k < 10; k++) begin
      wbuf[k] = 8'h90 + 8'(k);
      a = {4'h8, 3'(3'd6 + 3'(k))};
      exp_m[a] = wbuf[k];
    end
    write_bytes("R5 page write", 7'h46, 10);
    wait_ready("R6 ready after page write");
    read_seq(7'h40, 9);
    for (int k = 0; k < 9; k++) chk("R5 page contents", rbuf[k], exp_m[7'h40 + 7'(k)]);
  endtask

  task automatic t_we_low();
    bit ack;
    wr_en = 1'b0;
    wbuf[0] = 8'hEE;
    write_bytes("R7 acks with write enable low", 7'h10, 1);
    poll(ack);
    chk("R7 no write cycle", ack, 1);
    wr_en = 1'b1;
    read_seq(7'h10, 1);
    chk("R7 data unchanged", rbuf[0], exp_m[7'h10]);
  endtask

  task automatic t_seq_wrap();
    read_seq(7'h7E, 4);
    chk("R9 seq byte 0", rbuf[0], exp_m[7'h7E]);
    chk("R9 seq byte 1", rbuf[1], exp_m[7'h7F]);
    chk("R9 wrap to 0", rbuf[2], exp_m[7'h00]);
    chk("R9 seq byte 3", rbuf[3], exp_m[7'h01]);
  endtask

  task automatic t_current();
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte(8'hA1, ack);
    recv_byte(1'b0, d);
    chk("R10 current address read", d, exp_m[7'h02]);
    hq();
    chk("R11 SDA released after NACK", sda_pd, 0);
    scl = 1'b1; hq();
    chk("R11 SDA stays released", sda_pd, 0);
    scl = 1'b0; hq();
    bus_stop();
    poll(ack);
    chk("R12 standby after read STOP", ack, 1);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]   = 8'(i * 7 + 3) ^ 8'h5A;
      exp_m[i] = 8'(i * 7 + 3) ^ 8'h5A;
    end
    rst = 1'b1; scl = 1'b1; sda_m = 1'b1; wr_en = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    hq();
    t_reset();
    t_no_start();
    t_select();
    t_byte_write();
    t_page_write();
    t_we_low();
    t_seq_wrap();
    t_current();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule